// File: doc/BRIEF.md
# Serial Clock Rate Generator

This block sets the pace of a serial shift engine. It runs on a 60 MHz master clock. It turns that clock into single-cycle strobes that mark each half-period of a serial clock, together with the serial clock level itself. The shift engine uses the rising and falling indications to know when to launch data and when to sample it. The serial clock idles low.

The rate is programmed in-band, from the same byte stream that carries the engine's commands. One opcode switches on a fixed divide-by-5 prescaler ahead of the divider. Another opcode switches the prescaler off. A third opcode loads a 16-bit divisor from the next two bytes. One half-period lasts `(divisor + 1) * 5` master cycles when the prescaler is on, and `divisor + 1` master cycles when it is off. The serial frequency is therefore the base clock divided by `2 * (divisor + 1)`, where the base clock is 12 MHz or 60 MHz.

Reprogramming is glitch-free. New settings are held as pending values. They are copied into the active divider only at the end of a full serial period, when the clock falls back to low.

Top module: `sclk_rate_gen`

## Requirements
- R1: While reset is applied, and during the two-cycle synchronised reset release, `sclk_level` is 0 and no strobe is raised. Reset leaves the prescaler on and the divisor at 0. The first strobe is a rising one and appears in the sixth clock cycle after `rst_n` goes high.
- R2: With the prescaler on, every half-period lasts `(divisor + 1) * 5` master cycles. For example, divisor 0 gives 5 cycles (6 MHz at 60 MHz) and divisor 119 gives 600 cycles (50 kHz).
- R3: With the prescaler off, every half-period lasts `divisor + 1` master cycles. With divisor 0 this gives a strobe on every cycle.
- R4: The opcode byte 0x8B, taken while no divisor load is in progress, selects the prescaler. The opcode byte 0x8A, taken under the same condition, deselects it.
- R5: The opcode byte 0x86 makes the next two accepted bytes the divisor: first the low byte, then the high byte. These two bytes are always taken as data, even when their values match an opcode.
- R6: A byte is accepted only in a cycle where `cfg_valid` is high. An accepted byte that is not one of 0x86, 0x8A or 0x8B, and that arrives while no divisor load is in progress, changes nothing.
- R7: A new divisor or prescaler setting first affects the low half-period that follows the next falling strobe. The half-period in progress, and a high half-period that is already under way, keep their old length.
- R8: The strobes alternate between rising and falling, starting with rising. `sclk_rise` and `sclk_fall` never occur together. `sclk_level` changes in the cycle after a strobe, and only then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 60 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_valid | input | 1 | Qualifies `cfg_byte` for one cycle |
| cfg_byte | input | 8 | Command-stream byte: an opcode or a divisor byte |
| sclk_tick | output | 1 | One-cycle strobe at each serial half-period boundary |
| sclk_rise | output | 1 | Strobe marks the serial clock going high |
| sclk_fall | output | 1 | Strobe marks the serial clock going low (end of the period) |
| sclk_level | output | 1 | Current serial clock level |

## Verification
Most internal faults show up as a strobe spacing that differs from `(divisor + 1)` times the prescale factor. A wrong prescaler count or half-period counter is visible at the very next strobe, within at most one half-period. A wrong pending or active configuration stays hidden until the first falling strobe after a reprogramming, and is then exposed by the following half-period. A reference model advances with the block on every clock and compares all four outputs. It is backed by directed measurements of the strobe spacing before and after each reprogramming.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_PRE_OFF = 8'h8A;
  localparam logic [BYTE_W-1:0] OP_PRE_ON  = 8'h8B;
  localparam logic [BYTE_W-1:0] OP_SET_DIV = 8'h86;

  typedef enum logic [1:0] {
    DEC_IDLE = 2'd0,
    DEC_LO   = 2'd1,
    DEC_HI   = 2'd2
  } dec_state_e;
endpackage

// File: rtl/sclk_cfg_decode.sv
module sclk_cfg_decode
  import sclk_gen_pkg::*;
#(
  parameter int DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              pend_pre_o,
  output logic [DIV_W-1:0]  pend_div_o,
  output logic              idle_o
);
  dec_state_e        state_q, state_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              pre_q, pre_d;
  logic [DIV_W-1:0]  div_q, div_d;

  always_comb begin
    state_d = state_q;
    lo_d    = lo_q;
    pre_d   = pre_q;
    div_d   = div_q;
    if (byte_vld_i) begin
      unique case (state_q)
        DEC_IDLE: begin
          if (byte_i == OP_PRE_ON)       pre_d   = 1'b1;
          else if (byte_i == OP_PRE_OFF) pre_d   = 1'b0;
          else if (byte_i == OP_SET_DIV) state_d = DEC_LO;
        end
        DEC_LO: begin
          lo_d    = byte_i;
          state_d = DEC_HI;
        end
        DEC_HI: begin
          div_d   = DIV_W'({byte_i, lo_q});
          state_d = DEC_IDLE;
        end
        default: state_d = DEC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DEC_IDLE;
      lo_q    <= '0;
      pre_q   <= 1'b1;
      div_q   <= '0;
    end else begin
      state_q <= state_d;
      lo_q    <= lo_d;
      pre_q   <= pre_d;
      div_q   <= div_d;
    end
  end

  assign pend_pre_o = pre_q;
  assign pend_div_o = div_q;
  assign idle_o     = (state_q == DEC_IDLE);
endmodule

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
  parameter int RATIO = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_en_i,
  output logic base_en_o
);
  generate
    if (RATIO > 1) begin : g_div
      localparam int CNT_W = $clog2(RATIO);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             wrap;

      assign wrap = (cnt_q == LAST);

      always_comb begin
        cnt_d = '0;
        if (div_en_i && !wrap) cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign base_en_o = !div_en_i || wrap;
    end else begin : g_pass
      assign base_en_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/sclk_half_count.sv
module sclk_half_count #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_en_i,
  input  logic             pend_pre_i,
  input  logic [DIV_W-1:0] pend_div_i,
  output logic             tick_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             level_o,
  output logic             act_pre_o,
  output logic [DIV_W-1:0] act_div_o
);
  logic [DIV_W-1:0] hc_q, hc_d;
  logic             lvl_q, lvl_d;
  logic             apre_q, apre_d;
  logic [DIV_W-1:0] adiv_q, adiv_d;
  logic             tick, fall;

  assign tick = base_en_i && (hc_q == adiv_q);
  assign fall = tick && lvl_q;

  always_comb begin
    hc_d   = hc_q;
    lvl_d  = lvl_q;
    apre_d = apre_q;
    adiv_d = adiv_q;
    if (tick) begin
      hc_d  = '0;
      lvl_d = !lvl_q;
    end else if (base_en_i) begin
      hc_d = hc_q + 1'b1;
    end
    if (fall) begin
      apre_d = pend_pre_i;
      adiv_d = pend_div_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q   <= '0;
      lvl_q  <= 1'b0;
      apre_q <= 1'b1;
      adiv_q <= '0;
    end else begin
      hc_q   <= hc_d;
      lvl_q  <= lvl_d;
      apre_q <= apre_d;
      adiv_q <= adiv_d;
    end
  end

  assign tick_o    = tick;
  assign rise_o    = tick && !lvl_q;
  assign fall_o    = fall;
  assign level_o   = lvl_q;
  assign act_pre_o = apre_q;
  assign act_div_o = adiv_q;
endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
  import sclk_gen_pkg::*;
#(
  parameter int PRE_RATIO   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [BYTE_W-1:0] cfg_byte,
  output logic              sclk_tick,
  output logic              sclk_rise,
  output logic              sclk_fall,
  output logic              sclk_level
);
  localparam int DIV_W = 2 * BYTE_W;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_sync;
  logic                   dec_idle;
  logic                   pend_pre, act_pre;
  logic [DIV_W-1:0]       pend_div, act_div;
  logic                   base_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[SYNC_STAGES-1];

  sclk_cfg_decode #(.DIV_W(DIV_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .byte_vld_i (cfg_valid),
    .byte_i     (cfg_byte),
    .pend_pre_o (pend_pre),
    .pend_div_o (pend_div),
    .idle_o     (dec_idle)
  );

  sclk_prescale #(.RATIO(PRE_RATIO)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .div_en_i  (act_pre),
    .base_en_o (base_en)
  );

  sclk_half_count #(.DIV_W(DIV_W)) u_half (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .base_en_i  (base_en),
    .pend_pre_i (pend_pre),
    .pend_div_i (pend_div),
    .tick_o     (sclk_tick),
    .rise_o     (sclk_rise),
    .fall_o     (sclk_fall),
    .level_o    (sclk_level),
    .act_pre_o  (act_pre),
    .act_div_o  (act_div)
  );
endmodule

// File: rtl/sclk_rate_gen_chk.sv
module sclk_rate_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic [7:0]       cfg_byte,
  input logic             dec_idle,
  input logic             pend_pre,
  input logic [DIV_W-1:0] pend_div,
  input logic             act_pre,
  input logic [DIV_W-1:0] act_div,
  input logic             sclk_tick,
  input logic             sclk_rise,
  input logic             sclk_fall,
  input logic             sclk_level
);
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sclk_rise, sclk_fall})); // R8

  AST_TICK_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_tick |=> (sclk_level != $past(sclk_level))); // R8

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_tick |=> $stable(sclk_level)); // R8

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> ($stable(act_div) && $stable(act_pre))); // R7

  AST_PRE_OFF_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && dec_idle && cfg_byte == 8'h8A) |=> !pend_pre); // R4

  AST_PRE_ON_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && dec_idle && cfg_byte == 8'h8B) |=> pend_pre); // R4

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> ($stable(pend_div) && $stable(pend_pre))); // R6
endmodule

bind sclk_rate_gen sclk_rate_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .cfg_valid  (cfg_valid),
  .cfg_byte   (cfg_byte),
  .dec_idle   (dec_idle),
  .pend_pre   (pend_pre),
  .pend_div   (pend_div),
  .act_pre    (act_pre),
  .act_div    (act_div),
  .sclk_tick  (sclk_tick),
  .sclk_rise  (sclk_rise),
  .sclk_fall  (sclk_fall),
  .sclk_level (sclk_level)
);

// File: tb/sclk_rate_gen_tb.sv
`timescale 1ns/100ps
module sclk_rate_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_valid;
  logic [7:0] cfg_byte;
  logic       sclk_tick, sclk_rise, sclk_fall, sclk_level;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sclk_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_byte(cfg_byte),
    .sclk_tick(sclk_tick), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sclk_level(sclk_level)
  );

  // Behavioural reference: half-period length computed from settings
  int  m_sync, m_cnt, m_dstate, m_lo;
  int  m_pdiv, m_adiv;
  bit  m_ppre, m_apre, m_phase;

  function automatic int half_len(int dv, bit pre);
    return (dv + 1) * (pre ? 5 : 1);
  endfunction

  function automatic bit m_tick();
    return (m_sync == 2) && (m_cnt == half_len(m_adiv, m_apre) - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_cnt = 0; m_dstate = 0; m_lo = 0;
      m_pdiv = 0; m_adiv = 0; m_ppre = 1; m_apre = 1; m_phase = 0;
    end else if (m_sync < 2) begin
      m_sync = m_sync + 1;
    end else begin
      if (m_tick()) begin
        if (m_phase) begin
          m_apre = m_ppre;
          m_adiv = m_pdiv;
        end
        m_phase = !m_phase;
        m_cnt = 0;
      end else begin
        m_cnt = m_cnt + 1;
      end
      if (cfg_valid) begin
        case (m_dstate)
          0: begin
            if (cfg_byte == 8'h8B) m_ppre = 1;
            else if (cfg_byte == 8'h8A) m_ppre = 0;
            else if (cfg_byte == 8'h86) m_dstate = 1;
          end
          1: begin m_lo = cfg_byte; m_dstate = 2; end
          default: begin m_pdiv = cfg_byte * 256 + m_lo; m_dstate = 0; end
        endcase
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R2/R3/R7/R8)
  always @(negedge clk) begin
    if (chk_on && !done) begin
      bit et;
      et = m_tick();
      check("R8 model tick",  sclk_tick,  et);
      check("R8 model rise",  sclk_rise,  et && !m_phase);
      check("R8 model fall",  sclk_fall,  et && m_phase);
      check("R7 model level", sclk_level, m_phase);
    end
  end

  task automatic send(logic [7:0] b);
    cfg_valid = 1'b1;
    cfg_byte  = b;
    @(negedge clk);
    cfg_valid = 1'b0;
    cfg_byte  = 8'h00;
  endtask

  task automatic wait_fall();
    do @(negedge clk); while (!sclk_fall);
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!sclk_rise);
  endtask

  task automatic to_next(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sclk_tick);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #150000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b1; cfg_valid = 1'b0; cfg_byte = 8'h00;
    #2 rst_n = 1'b0;
    chk_on = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset level", sclk_level, 0);
    check("R1 reset tick",  sclk_tick, 0);
    rst_n = 1'b1;
    to_next(n);
    check("R1 first strobe cycle", n, 6);
    check("R1 first strobe is rise", sclk_rise, 1);

    // R2 default 6 MHz and R8 alternation
    to_next(n);
    check("R2 default half", n, 5);
    check("R8 second strobe falls", sclk_fall, 1);
    to_next(n);
    check("R8 third strobe rises", sclk_rise, 1);

    // R5/R2: divisor 119 -> 600-cycle half (50 kHz)
    send(8'h86); send(8'd119); send(8'h00);
    wait_fall();
    to_next(n);
    check("R2 div119 half", n, 600);

    // R7: reprogram during a high half, old length kept
    wait_rise();
    n = 0;
    cfg_valid = 1'b1; cfg_byte = 8'h86; @(negedge clk); n++;
    cfg_byte = 8'h03; @(negedge clk); n++;
    cfg_byte = 8'h00; @(negedge clk); n++;
    cfg_valid = 1'b0;
    begin
      int m;
      to_next(m);
      check("R7 in-progress half keeps old", n + m, 600);
    end
    to_next(n);
    check("R7 new setting after fall", n, 20);

    // R3/R4: prescaler off
    send(8'h8A);
    wait_fall();
    to_next(n);
    check("R3 pre off div3", n, 4);
    send(8'h8B);
    wait_fall();
    to_next(n);
    check("R4 pre back on", n, 20);

    // R6: unknown opcodes and unqualified bytes ignored
    send(8'h55); send(8'h8C); send(8'hFF);
    cfg_byte = 8'h8A; @(negedge clk); cfg_byte = 8'h00;
    wait_fall();
    to_next(n);
    check("R6 ignored bytes", n, 20);

    // R3: divisor 0, prescaler off -> strobe every cycle
    send(8'h86); send(8'h00); send(8'h00); send(8'h8A);
    wait_fall();
    to_next(n);
    check("R3 div0 every cycle", n, 1);
    to_next(n);
    check("R3 div0 next", n, 1);

    // R5: opcode-valued data bytes are data
    send(8'h8B);
    send(8'h86); send(8'h8A); send(8'h00);
    wait_fall();
    to_next(n);
    check("R5 data byte 0x8A as divisor", n, 695);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule